// File: doc/BRIEF.md
# Device interrupt mask router

This block steers a set of device interrupt request lines to a small group of processors. Every processor owns a mask that selects the request lines it wants to hear. A single pending vector records which lines are currently raised, and is shared by all processors. For each processor the block derives an active set, which is its mask ANDed with the pending vector, and drives a level interrupt that is high while that set is not empty.

Devices raise and drop their lines through per-line post and clear strobes. Software programs the masks through a small register port and reads back masks, active sets and the pending vector as full 64-bit words. Besides the level output, each processor gets two one-cycle event pulses. An assert pulse marks an interrupt being delivered to that processor. A deassert pulse marks one of its active bits going away. Downstream logic that counts deliveries or wakes a core can use these pulses.

Top module: `irq_mask_router`

## Requirements
- R1: After reset the masks and the pending vector are zero, every register reads zero, and all dev_irq, irq_rise_evt and irq_fall_evt outputs are low.
- R2: A write with reg_addr = {2'b00, cpu} loads that processor's mask from reg_wdata[NUM_LINES-1:0]. A read at that address returns the mask, with bits NUM_LINES and above reading zero.
- R3: A read at {2'b01, cpu} returns that processor's mask AND pending. A read at {2'b10, any} returns the pending vector. A read at {2'b11, any} returns zero. Reads are combinational from reg_raddr.
- R4: Writes to addresses whose upper two bits are 01, 10 or 11 change no mask and no pending bit.
- R5: A high bit n of line_post sets pending bit n at the next clock edge. Several lines may be posted in one cycle.
- R6: A high bit n of line_clear clears pending bit n. When bit n is already zero the clear is spurious and changes no state.
- R7: When line_post and line_clear are both high for the same line in one cycle, the line ends up pending.
- R8: dev_irq[c] is registered and equals the OR of processor c's active set, one cycle after the triggering write or strobe.
- R9: irq_rise_evt[c] pulses for one cycle, one cycle after a post, when processor c's mask has any of the posted bits set. The mask used is the value after any mask write in the same cycle. The pulse occurs even when the line was already pending.
- R10: irq_rise_evt[c] pulses one cycle after a write to processor c's mask when a mask bit that changed is now both masked in and pending.
- R11: irq_fall_evt[c] pulses one cycle after any cycle in which a bit of processor c's active set goes from 1 to 0. This covers both mask writes and line clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Write address {kind, cpu} |
| reg_wdata | input | DATA_W | Write data |
| reg_raddr | input | ADDR_W | Read address {kind, cpu} |
| reg_rdata | output | DATA_W | Read data, combinational |
| line_post | input | NUM_LINES | Per-line request post strobes |
| line_clear | input | NUM_LINES | Per-line request clear strobes |
| dev_irq | output | NUM_CPUS | Per-processor interrupt level |
| irq_rise_evt | output | NUM_CPUS | Per-processor assert event pulse |
| irq_fall_evt | output | NUM_CPUS | Per-processor deassert event pulse |

## Verification
The bench builds the block with 8 request lines, 2 processors and a 64-bit data word, which gives a 3-bit address. With only 8 lines, all 256 mask values can be written to one processor against a fixed pending pattern. This covers every combination of changed, pending and previously active bits for the assert and deassert rules. Each line is also walked one at a time through post, combined post and clear, real clear and spurious clear, against two processors with disjoint masks.

// File: rtl/irq_mask_router_pkg.sv
package irq_mask_router_pkg;

   typedef enum logic [1:0] {
      KIND_MASK   = 2'd0,
      KIND_ACTIVE = 2'd1,
      KIND_PEND   = 2'd2,
      KIND_NONE   = 2'd3
   } reg_kind_e;

   function automatic int unsigned cpu_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/irq_mask_router_pending.sv
module irq_mask_router_pending #(
   parameter int unsigned NUM_LINES = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] line_post,
   input  logic [NUM_LINES-1:0] line_clear,
   output logic [NUM_LINES-1:0] pend_q,
   output logic [NUM_LINES-1:0] pend_nxt
);

   // post wins over clear; clearing an idle bit leaves it idle
   assign pend_nxt = (pend_q & ~line_clear) | line_post;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_nxt;
   end

   // R5
   post_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|line_post) |=> ((pend_q & $past(line_post)) == $past(line_post)));

   // R6
   spurious_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(line_clear & ~pend_q & ~line_post)) |=>
      ((pend_q & $past(line_clear & ~pend_q & ~line_post)) == '0));

   // R6
   real_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(line_clear & ~line_post)) |=>
      ((pend_q & $past(line_clear & ~line_post)) == '0));

endmodule

// File: rtl/irq_mask_router_slice.sv
module irq_mask_router_slice #(
   parameter int unsigned NUM_LINES = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_sel,
   input  logic [NUM_LINES-1:0] wr_mask,
   input  logic [NUM_LINES-1:0] pend_q,
   input  logic [NUM_LINES-1:0] pend_nxt,
   input  logic [NUM_LINES-1:0] post_vec,
   output logic [NUM_LINES-1:0] mask_q,
   output logic [NUM_LINES-1:0] act,
   output logic                 irq_q,
   output logic                 rise_q,
   output logic                 fall_q
);

   logic [NUM_LINES-1:0] mask_nxt;
   logic [NUM_LINES-1:0] act_nxt;
   logic                 rise_d;
   logic                 fall_d;

   assign mask_nxt = wr_sel ? wr_mask : mask_q;
   assign act      = mask_q & pend_q;
   assign act_nxt  = mask_nxt & pend_nxt;

   always_comb begin
      rise_d = |(post_vec & mask_nxt);
      if (wr_sel && (|((mask_q ^ mask_nxt) & act_nxt)))
         rise_d = 1'b1;
      fall_d = |(act & ~act_nxt);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         irq_q  <= 1'b0;
         rise_q <= 1'b0;
         fall_q <= 1'b0;
      end else begin
         mask_q <= mask_nxt;
         irq_q  <= |act_nxt;
         rise_q <= rise_d;
         fall_q <= fall_d;
      end
   end

   // R8
   irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_q == (|(mask_q & pend_q))));

   // R9
   irq_rise_has_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> rise_q);

   // R11
   irq_fall_has_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_q) |-> fall_q);

endmodule

// File: rtl/irq_mask_router_rdmux.sv
module irq_mask_router_rdmux
   import irq_mask_router_pkg::*;
#(
   parameter int unsigned NUM_LINES = 64,
   parameter int unsigned NUM_CPUS  = 4,
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned CPU_W     = 2
) (
   input  logic [CPU_W+1:0]                    raddr,
   input  logic [NUM_CPUS-1:0][NUM_LINES-1:0]  mask_all,
   input  logic [NUM_CPUS-1:0][NUM_LINES-1:0]  act_all,
   input  logic [NUM_LINES-1:0]                pend,
   output logic [DATA_W-1:0]                   rdata
);

   reg_kind_e        rkind;
   logic [CPU_W-1:0] rcpu;

   assign rkind = reg_kind_e'(raddr[CPU_W+1 -: 2]);
   assign rcpu  = raddr[CPU_W-1:0];

   always_comb begin
      rdata = '0;
      case (rkind)
         KIND_MASK: begin
            for (int c = 0; c < int'(NUM_CPUS); c++)
               if (rcpu == CPU_W'(c)) rdata[NUM_LINES-1:0] = mask_all[c];
         end
         KIND_ACTIVE: begin
            for (int c = 0; c < int'(NUM_CPUS); c++)
               if (rcpu == CPU_W'(c)) rdata[NUM_LINES-1:0] = act_all[c];
         end
         KIND_PEND: rdata[NUM_LINES-1:0] = pend;
         default:   rdata = '0;
      endcase
   end

endmodule

// File: rtl/irq_mask_router.sv
module irq_mask_router
   import irq_mask_router_pkg::*;
#(
   parameter  int unsigned NUM_LINES = 64,
   parameter  int unsigned NUM_CPUS  = 4,
   parameter  int unsigned DATA_W    = 64,
   localparam int unsigned CPU_W     = cpu_bits(NUM_CPUS),
   localparam int unsigned ADDR_W    = CPU_W + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   input  logic [ADDR_W-1:0]    reg_raddr,
   output logic [DATA_W-1:0]    reg_rdata,
   input  logic [NUM_LINES-1:0] line_post,
   input  logic [NUM_LINES-1:0] line_clear,
   output logic [NUM_CPUS-1:0]  dev_irq,
   output logic [NUM_CPUS-1:0]  irq_rise_evt,
   output logic [NUM_CPUS-1:0]  irq_fall_evt
);

   if (NUM_LINES < 1 || NUM_LINES > DATA_W) begin : g_bad_lines
      $error("NUM_LINES must lie in 1..DATA_W");
   end
   if (NUM_CPUS < 1) begin : g_bad_cpus
      $error("NUM_CPUS must be at least 1");
   end
   if (DATA_W > 64) begin : g_bad_width
      $error("DATA_W must not exceed 64");
   end

   logic [NUM_LINES-1:0]               pend_q;
   logic [NUM_LINES-1:0]               pend_nxt;
   logic [NUM_CPUS-1:0][NUM_LINES-1:0] mask_all;
   logic [NUM_CPUS-1:0][NUM_LINES-1:0] act_all;
   logic [NUM_CPUS-1:0]                wr_sel;
   reg_kind_e                          wkind;
   logic [CPU_W-1:0]                   wcpu;
   logic                               unused_wdata;

   assign wkind        = reg_kind_e'(reg_addr[ADDR_W-1 -: 2]);
   assign wcpu         = reg_addr[CPU_W-1:0];
   assign unused_wdata = ^reg_wdata;

   irq_mask_router_pending #(.NUM_LINES(NUM_LINES)) u_pending (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_post  (line_post),
      .line_clear (line_clear),
      .pend_q     (pend_q),
      .pend_nxt   (pend_nxt)
   );

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      assign wr_sel[c] = reg_wr && (wkind == KIND_MASK) && (wcpu == CPU_W'(c));

      irq_mask_router_slice #(.NUM_LINES(NUM_LINES)) u_slice (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_sel   (wr_sel[c]),
         .wr_mask  (reg_wdata[NUM_LINES-1:0]),
         .pend_q   (pend_q),
         .pend_nxt (pend_nxt),
         .post_vec (line_post),
         .mask_q   (mask_all[c]),
         .act      (act_all[c]),
         .irq_q    (dev_irq[c]),
         .rise_q   (irq_rise_evt[c]),
         .fall_q   (irq_fall_evt[c])
      );
   end

   irq_mask_router_rdmux #(
      .NUM_LINES (NUM_LINES),
      .NUM_CPUS  (NUM_CPUS),
      .DATA_W    (DATA_W),
      .CPU_W     (CPU_W)
   ) u_rdmux (
      .raddr    (reg_raddr),
      .mask_all (mask_all),
      .act_all  (act_all),
      .pend     (pend_q),
      .rdata    (reg_rdata)
   );

   // R4
   ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && wkind != KIND_MASK) |=> $stable(mask_all));

   // R2
   one_mask_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_sel));

endmodule

// File: tb/irq_mask_router_tb.sv
`timescale 1ns/100ps
module irq_mask_router_tb;

   localparam int NL = 8;
   localparam int NC = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          reg_wr;
   logic [2:0]    reg_addr;
   logic [63:0]   reg_wdata;
   logic [2:0]    reg_raddr;
   logic [63:0]   reg_rdata;
   logic [NL-1:0] line_post;
   logic [NL-1:0] line_clear;
   logic [NC-1:0] dev_irq;
   logic [NC-1:0] irq_rise_evt;
   logic [NC-1:0] irq_fall_evt;

   int checks = 0;
   int errors = 0;

   logic [NL-1:0] m_mask [NC];
   logic [NL-1:0] m_pend;

   always #4 clk = ~clk;

   irq_mask_router #(.NUM_LINES(NL), .NUM_CPUS(NC), .DATA_W(64)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_wr       (reg_wr),
      .reg_addr     (reg_addr),
      .reg_wdata    (reg_wdata),
      .reg_raddr    (reg_raddr),
      .reg_rdata    (reg_rdata),
      .line_post    (line_post),
      .line_clear   (line_clear),
      .dev_irq      (dev_irq),
      .irq_rise_evt (irq_rise_evt),
      .irq_fall_evt (irq_fall_evt)
   );

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic read_chk(input string tag, input logic [2:0] a, input logic [63:0] exp);
      reg_raddr = a;
      #0.2;
      check(tag, reg_rdata, exp);
   endtask

   task automatic check_regs(input string tag);
      for (int c = 0; c < NC; c++) begin
         read_chk({tag, " R2 mask"}, {2'b00, c[0]}, {56'd0, m_mask[c]});
         read_chk({tag, " R3 active"}, {2'b01, c[0]}, {56'd0, m_mask[c] & m_pend});
      end
      read_chk({tag, " R3 pending"}, 3'b100, {56'd0, m_pend});
      read_chk({tag, " R3 none"}, 3'b111, 64'd0);
   endtask

   task automatic step(input string tag, input logic wr, input logic [2:0] a,
                       input logic [63:0] wd, input logic [NL-1:0] post,
                       input logic [NL-1:0] clr);
      logic [NL-1:0] mn [NC];
      logic [NL-1:0] pn;
      logic [NC-1:0] e_irq, e_rise, e_fall;
      logic          sel;
      pn = (m_pend & ~clr) | post;
      for (int c = 0; c < NC; c++) begin
         sel = wr && a[2:1] == 2'b00 && a[0] == c[0];
         mn[c] = sel ? wd[NL-1:0] : m_mask[c];
         e_irq[c]  = |(mn[c] & pn);
         e_rise[c] = (|(post & mn[c])) || (sel && (|((m_mask[c] ^ mn[c]) & mn[c] & pn)));
         e_fall[c] = |((m_mask[c] & m_pend) & ~(mn[c] & pn));
      end
      reg_wr = wr; reg_addr = a; reg_wdata = wd; line_post = post; line_clear = clr;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0; line_post = '0; line_clear = '0;
      for (int c = 0; c < NC; c++) m_mask[c] = mn[c];
      m_pend = pn;
      check({tag, " R8 irq"}, {62'd0, dev_irq}, {62'd0, e_irq});
      check({tag, " R9/R10 rise"}, {62'd0, irq_rise_evt}, {62'd0, e_rise});
      check({tag, " R11 fall"}, {62'd0, irq_fall_evt}, {62'd0, e_fall});
      check_regs(tag);
   endtask

   initial begin
      #(200000 * 8);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
      reg_raddr = '0; line_post = '0; line_clear = '0;
      m_mask[0] = '0; m_mask[1] = '0; m_pend = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check("R1 irq", {62'd0, dev_irq}, 64'd0);
      check("R1 rise", {62'd0, irq_rise_evt}, 64'd0);
      check("R1 fall", {62'd0, irq_fall_evt}, 64'd0);
      check_regs("R1");

      // upper data bits are dropped
      step("R2 wide", 1'b1, 3'b000, 64'hFFFF_FFFF_FFFF_FF81, '0, '0);
      step("R5 post0", 1'b0, 3'b000, 64'd0, 8'h01, '0);
      step("R9 repost", 1'b0, 3'b000, 64'd0, 8'h01, '0);
      step("R6 clr0", 1'b0, 3'b000, 64'd0, '0, 8'h01);
      step("R5 multi", 1'b0, 3'b000, 64'd0, 8'hA5, '0);

      for (int v = 0; v < 256; v++) begin
         step("R10 sweep0", 1'b1, 3'b000, 64'(v), '0, '0);
         step("R11 sweep1", 1'b1, 3'b001, 64'(~v & 8'hFF), '0, '0);
      end

      step("R4 wr act", 1'b1, 3'b010, 64'hFF, '0, '0);
      step("R4 wr pend", 1'b1, 3'b100, 64'hFF, '0, '0);
      step("R4 wr none", 1'b1, 3'b111, 64'hFF, '0, '0);

      step("R2 m0", 1'b1, 3'b000, 64'h0F, '0, '0);
      step("R2 m1", 1'b1, 3'b001, 64'hF0, '0, '0);
      step("R11 clrall", 1'b0, 3'b000, 64'd0, '0, 8'hFF);
      for (int n = 0; n < NL; n++) begin
         step("R9 post", 1'b0, 3'b000, 64'd0, 8'(1 << n), '0);
         step("R6 clear", 1'b0, 3'b000, 64'd0, '0, 8'(1 << n));
         step("R6 spurious", 1'b0, 3'b000, 64'd0, '0, 8'(1 << n));
         step("R7 both", 1'b0, 3'b000, 64'd0, 8'(1 << n), 8'(1 << n));
         step("R9 wr+post", 1'b1, 3'b001, 64'hFF, 8'(1 << n), '0);
         step("R10 restore", 1'b1, 3'b001, 64'hF0, '0, 8'(1 << n));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule